// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block is the digital heart of a supply supervisor. It holds an active-low system reset, `sys_rst_n`, low while the supply is out of range or a manual reset is requested. After either cause clears, it keeps the reset low for a fixed number of clock cycles before releasing it. A second active-low output, `wd_fault_n`, reports watchdog expiry on its own and never stands in for the system reset. The voltage comparison happens elsewhere and arrives as a one-bit supply-good flag. Both outputs are plain logic levels, low when asserted.

Software keeps the watchdog quiet by producing high-to-low transitions on `kick`. If the selected window passes without one, `wd_fault_n` pulses low for one reset-delay length, and a new window begins. The window length comes from a two-bit code and a long/short flag. Holding `wd_sel` low switches the watchdog off completely. The manual reset and kick pins are asynchronous and are synchronised internally. The supply flag and selection pins are taken as already synchronous.

Top module: `sup_wdt_top`

## Requirements
- R1: While the controller reset `rst` is high, `sys_rst_n` is 0 and `wd_fault_n` is 1. After `rst` falls, `sys_rst_n` rises exactly RST_DLY_CYC (default 20) clock cycles later.
- R2: A low `supply_ok` sampled at a clock edge drives `sys_rst_n` low at that same edge.
- R3: Once `supply_ok` is high, `sys_rst_n` rises after RST_DLY_CYC consecutive cycles of good supply. Any dip restarts the count from zero.
- R4: A low `mr_n` asserts `sys_rst_n` within three clock edges. After `mr_n` returns high, `sys_rst_n` rises RST_DLY_CYC+2 cycles later (two cycles of synchronisation plus the delay).
- R5: The window length is T = WD_BASE_CYC × 2^code, where code is `tmo_code` (0..3), multiplied by 2^EXT_SHIFT when `tmo_ext`=1. Defaults: 16/32/64/128 when `tmo_ext`=0 and 64/128/256/512 when `tmo_ext`=1. With no kick, `wd_fault_n` falls exactly T cycles after `sys_rst_n` rises.
- R6: A high-to-low transition on `kick` restarts the window. The fault then falls T+3 cycles after that transition (two synchroniser stages and one edge stage). Kicking more often than T keeps `wd_fault_n` high.
- R7: A fault holds `wd_fault_n` low for exactly RST_DLY_CYC cycles. The next window starts on release, so the next fault follows T cycles later.
- R8: `wd_fault_n` can fall only in a cycle where `sys_rst_n` was high. Once `sys_rst_n` goes low, `wd_fault_n` is released at the following edge.
- R9: Activity on `kick` is ignored while `sys_rst_n` or `wd_fault_n` is low. A fault keeps its full length, and the window after a reset release is a full T.
- R10: With `wd_sel` low, `wd_fault_n` never falls. After `wd_sel` is raised, a fresh window starts and the fault falls T+1 cycles later (one cycle for the enable register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| supply_ok | input | 1 | Supply-good flag from the undervoltage comparator, 1 = in range |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| kick | input | 1 | Watchdog service input; falling edges restart the window |
| wd_sel | input | 1 | Watchdog enable, 0 = off |
| tmo_code | input | 2 | Window length code |
| tmo_ext | input | 1 | 1 = long window set |
| sys_rst_n | output | 1 | System reset, active low |
| wd_fault_n | output | 1 | Watchdog fault, active low |

## Verification
A stuck or miscounted reset-delay counter shows up as a release edge of `sys_rst_n` that is early, late or missing. That is visible within RST_DLY_CYC cycles of any supply or manual-reset event. A wrong window counter or a wrong table entry moves the first `wd_fault_n` falling edge after release, so every code/range pair is timed to the exact cycle. Gating faults, such as a fault that survives a reset or a kick accepted during a fault, change the fault width or the next window length. Those are visible at the ports within one RST_DLY_CYC + T period.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Width of the window selection code
    localparam int CODE_W      = 2;
    // Table size: every {range, code} pair
    localparam int TMO_ENTRIES = 2 ** (CODE_W + 1);

    typedef enum logic [0:0] {
        WD_RUN  = 1'b0,
        WD_TRIP = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic              ext;
        logic [CODE_W-1:0] code;
    } tmo_cfg_t;

    // Window length for table slot idx = {ext, code}
    function automatic int tmo_cycles(input int base, input int ext_shift, input int idx);
        int sh;
        sh = (idx % (2 ** CODE_W));
        if ((idx / (2 ** CODE_W)) != 0)
            sh = sh + ext_shift;
        return base << sh;
    endfunction

    // Longest window the table can hold
    function automatic int max_tmo(input int base, input int ext_shift);
        return base << ((2 ** CODE_W) - 1 + ext_shift);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RST_VAL;
            q  <= RST_VAL;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq #(
    parameter int RST_DLY = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic mr_s,
    output logic rst_n_o
);
    localparam int RW = $clog2(RST_DLY + 1);
    localparam logic [RW-1:0] LAST = RW'(RST_DLY - 1);

    logic [RW-1:0] cnt;
    logic          hold;

    // Any active cause keeps reset asserted and restarts the delay
    assign hold = ~supply_ok | ~mr_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            rst_n_o <= 1'b0;
        end else if (hold) begin
            cnt     <= '0;
            rst_n_o <= 1'b0;
        end else if (!rst_n_o) begin
            if (cnt == LAST) begin
                rst_n_o <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int RST_DLY = 20,
    parameter int CW      = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_n_i,
    input  logic          en_i,
    input  logic          kick_s,
    input  logic [CW-1:0] tmo_i,
    output logic          wdo_n_o
);
    localparam logic [CW-1:0] TRIP_LAST = CW'(RST_DLY - 1);

    wd_state_e     state;
    logic [CW-1:0] cnt;
    logic          en_q;
    logic          kick_d;
    logic          kick_fall;
    logic          kick_evt;
    logic          expired;

    assign kick_fall = kick_d & ~kick_s;
    // Kicks count only while both outputs are released and the watchdog is on
    assign kick_evt  = kick_fall & rst_n_i & (state == WD_RUN) & en_q;
    assign expired   = (cnt >= (tmo_i - CW'(1)));
    assign wdo_n_o   = (state != WD_TRIP);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            kick_d <= 1'b0;
        end else begin
            en_q   <= en_i;
            kick_d <= kick_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rst_n_i) begin
            state <= WD_RUN;
            cnt   <= '0;
        end else begin
            unique case (state)
                WD_RUN: begin
                    if (!en_q || kick_evt) begin
                        cnt <= '0;
                    end else if (expired) begin
                        state <= WD_TRIP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                WD_TRIP: begin
                    if (cnt == TRIP_LAST) begin
                        state <= WD_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= WD_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sup_wdt_top.sv
module sup_wdt_top
    import sup_pkg::*;
#(
    parameter int RST_DLY_CYC = 20,
    parameter int WD_BASE_CYC = 16,
    parameter int EXT_SHIFT   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              mr_n,
    input  logic              kick,
    input  logic              wd_sel,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              tmo_ext,
    output logic              sys_rst_n,
    output logic              wd_fault_n
);
    localparam int MAX_T = max_tmo(WD_BASE_CYC, EXT_SHIFT);
    localparam int CW    = $clog2(max2(MAX_T, RST_DLY_CYC) + 1);

    logic          mr_s;
    logic          kick_s;
    tmo_cfg_t      cfg;
    logic [CW-1:0] tmo_tab [TMO_ENTRIES];
    logic [CW-1:0] tmo_sel;

    // Manual reset idles high, as with a pull-up
    sup_sync2 #(.RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .rst(rst), .d(mr_n), .q(mr_s)
    );

    sup_sync2 #(.RST_VAL(1'b0)) u_kick_sync (
        .clk(clk), .rst(rst), .d(kick), .q(kick_s)
    );

    for (genvar gi = 0; gi < TMO_ENTRIES; gi++) begin : g_tmo
        assign tmo_tab[gi] = CW'(tmo_cycles(WD_BASE_CYC, EXT_SHIFT, gi));
    end

    assign cfg.ext  = tmo_ext;
    assign cfg.code = tmo_code;
    assign tmo_sel  = tmo_tab[cfg];

    sup_rst_seq #(.RST_DLY(RST_DLY_CYC)) u_rst_seq (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mr_s(mr_s), .rst_n_o(sys_rst_n)
    );

    sup_wdog #(.RST_DLY(RST_DLY_CYC), .CW(CW)) u_wdog (
        .clk(clk), .rst(rst), .rst_n_i(sys_rst_n), .en_i(wd_sel),
        .kick_s(kick_s), .tmo_i(tmo_sel), .wdo_n_o(wd_fault_n)
    );
endmodule

// File: rtl/sup_wdt_chk.sv
module sup_wdt_chk #(
    parameter int RST_DLY = 20
) (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic wd_sel,
    input logic sys_rst_n,
    input logic wd_fault_n
);
    localparam int LW = $clog2(RST_DLY + 2);
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || wd_fault_n) low_cnt <= '0;
        else if (low_cnt < LW'(RST_DLY + 1)) low_cnt <= low_cnt + 1'b1;
    end

    assert_uv_asserts_R2: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !sys_rst_n);

    assert_release_needs_supply_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> $past(supply_ok));

    assert_fault_width_R7: assert property (@(posedge clk) disable iff (rst)
        !wd_fault_n |-> (low_cnt < LW'(RST_DLY)));

    assert_fault_needs_release_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_fault_n) |-> $past(sys_rst_n));

    assert_reset_clears_fault_R8: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_n |=> wd_fault_n);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(!wd_sel) && $past(wd_fault_n)) |-> wd_fault_n);
endmodule

bind sup_wdt_top sup_wdt_chk #(.RST_DLY(RST_DLY_CYC)) u_chk (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wd_sel(wd_sel),
    .sys_rst_n(sys_rst_n), .wd_fault_n(wd_fault_n)
);

// File: tb/tb_sup_wdt_top.sv
module tb_sup_wdt_top;
    localparam int D     = 20;
    localparam int LIMIT = 5000;

    logic       clk = 1'b0;
    logic       rst, supply_ok, mr_n, kick, wd_sel, tmo_ext;
    logic [1:0] tmo_code;
    logic       sys_rst_n, wd_fault_n;
    int         n_chk = 0;
    int         n_bad = 0;

    // Stimulus {ext, code} with expected window length per R5
    localparam logic [2:0] V_CFG [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam int         V_TMO [8] = '{16, 32, 64, 128, 64, 128, 256, 512};

    always #2.5 clk = ~clk;

    sup_wdt_top dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mr_n(mr_n), .kick(kick),
        .wd_sel(wd_sel), .tmo_code(tmo_code), .tmo_ext(tmo_ext),
        .sys_rst_n(sys_rst_n), .wd_fault_n(wd_fault_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic until_rst_high(output int n);
        n = 0;
        while (sys_rst_n !== 1'b1 && n < LIMIT) begin @(negedge clk); n++; end
    endtask

    task automatic until_fault(input logic lvl, output int n);
        n = 0;
        while (wd_fault_n !== lvl && n < LIMIT) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int n;
        int low_seen;
        rst = 1; supply_ok = 1; mr_n = 1; kick = 1; wd_sel = 1; tmo_code = 0; tmo_ext = 0;
        repeat (3) @(negedge clk);
        check("R1 reset level", sys_rst_n, 0);
        check("R1 fault idle", wd_fault_n, 1);
        rst = 0;
        until_rst_high(n);
        check("R1 first release", n, D);

        // Table walk over every window setting
        for (int i = 0; i < 8; i++) begin
            {tmo_ext, tmo_code} = V_CFG[i];
            supply_ok = 0;
            @(negedge clk);
            check("R2 undervoltage", sys_rst_n, 0);
            @(negedge clk);
            check("R8 fault released", wd_fault_n, 1);
            supply_ok = 1;
            until_rst_high(n);   check("R3 release delay", n, D);
            until_fault(0, n);   check("R5 window", n, V_TMO[i]);
            until_fault(1, n);   check("R7 fault width", n, D);
            until_fault(0, n);   check("R7 next window", n, V_TMO[i]);
        end

        // R3: dip during the delay restarts it
        tmo_ext = 0; tmo_code = 0;
        supply_ok = 0; @(negedge clk); supply_ok = 1;
        repeat (5) @(negedge clk);
        supply_ok = 0; @(negedge clk); supply_ok = 1;
        until_rst_high(n);
        check("R3 dip restart", n, D);

        // R4: manual reset
        repeat (3) @(negedge clk);
        mr_n = 0;
        repeat (3) @(negedge clk);
        check("R4 manual assert", sys_rst_n, 0);
        repeat (10) @(negedge clk);
        mr_n = 1;
        until_rst_high(n);
        check("R4 manual release", n, D + 2);

        // R6: single kick restarts window
        repeat (5) @(negedge clk);
        kick = 0;
        until_fault(0, n);
        check("R6 kick restart", n, 16 + 3);

        // R9: kick toggling during fault does not shorten it
        n = 0;
        while (wd_fault_n === 1'b0 && n < LIMIT) begin
            kick = ~kick; @(negedge clk); n++;
        end
        check("R9 kick during fault", n, D);
        kick = 1;

        // R6: steady kicking keeps fault released
        supply_ok = 0; @(negedge clk); supply_ok = 1;
        until_rst_high(n);
        low_seen = 0;
        for (int k = 0; k < 120; k++) begin
            kick = ((k % 8) < 4) ? 1'b0 : 1'b1;
            @(negedge clk);
            if (wd_fault_n === 1'b0) low_seen++;
        end
        check("R6 periodic kicks", low_seen, 0);
        kick = 1;

        // R9: kicks during reset ignored, window full length
        supply_ok = 0;
        for (int k = 0; k < 10; k++) begin kick = ~kick; @(negedge clk); end
        kick = 1;
        supply_ok = 1;
        until_rst_high(n);   check("R9 release", n, D);
        until_fault(0, n);   check("R9 window after reset", n, 16);

        // R10: disabled watchdog stays quiet, re-enable starts fresh window
        wd_sel = 0;
        supply_ok = 0; @(negedge clk); supply_ok = 1;
        until_rst_high(n);
        low_seen = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (wd_fault_n === 1'b0) low_seen++;
        end
        check("R10 disabled", low_seen, 0);
        wd_sel = 1;
        until_fault(0, n);
        check("R10 re-enable window", n, 16 + 1);

        summary();
    end
endmodule